// File: doc/BRIEF.md
# Randomized Iterative Crossbar Matcher

This block schedules the crossbar of an input-queued switch that keeps one virtual output queue per output at every input. When started, it captures an N-by-N request matrix in which bit (i,j) says that input i holds cells for output j. It then runs rounds of three phases. In the request phase, every still-unpaired input asks every unpaired output it has cells for. In the grant phase, each unpaired output that was asked picks one asker at random. In the accept phase, each input that got grants keeps one of them at random. Every pair accepted in a round is frozen for the rest of the run. All ports choose independently and in parallel.

The run ends after the configured number of rounds, or earlier when a round adds no pair. At that point done rises and every input reports either the output it won or an invalid flag. The result stays put until the next start. Random choices come from one shift-register generator per port, each seeded differently. A chooser rotates the candidate vector by a random amount and takes the first set bit, so it always returns one of the real candidates.

The controller has four states. RESET_IDLE waits for the first start. GRANT_STEP latches the per-output grants. ACCEPT_STEP latches the accepts, updates the pairing and decides whether to stop. RESULT_HOLD shows the match. The transitions are: RESET_IDLE to GRANT_STEP on start; GRANT_STEP to ACCEPT_STEP always; ACCEPT_STEP to RESULT_HOLD on finish, or back to GRANT_STEP otherwise; RESULT_HOLD to GRANT_STEP on start.

Top module: `pim_sched`

## Requirements
- R1: While reset is asserted, and after it is released, done is low and every valid bit is low until a run completes.
- R2: In the cycle after an accepted start, done is low. Each round takes exactly two clock cycles, so done becomes visible 2*k cycles after the start edge when k rounds run.
- R3: Request bit (i,j) sits at position i*N+j of the request vector. A valid entry for input i with output index j only occurs when bit i*N+j of the captured request was set.
- R4: No output index appears in more than one valid entry.
- R5: At most L rounds run, where L is the round-limit input. A limit of 0 behaves as 1, and a limit above N behaves as N.
- R6: A run stops after the first round that adds no new pair, even when the limit allows more rounds.
- R7: When the effective limit is N, the final match is maximal: no request bit has both its input and its output unpaired.
- R8: When every input requests at most one output and no two inputs request the same output, every requesting input is paired with exactly its requested output, and every other input reports invalid.
- R9: After done rises, done, the valid bits and the indices stay unchanged until the next start, whatever the request and limit inputs do.
- R10: An output that is asked by several inputs can grant any one of them. Over repeated runs, every asking input wins at some point.
- R11: A start pulse that arrives while a run is in progress is ignored and does not change that run's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only when idle or holding a result |
| req_mat | input | N*N | Request matrix; bit i*N+j means input i has cells for output j |
| iter_lim | input | $clog2(N+1) | Maximum number of rounds (0 treated as 1, above N treated as N) |
| done | output | 1 | High while a finished match is presented |
| match_idx | output | N*$clog2(N) | Field i holds the output index paired with input i |
| match_vld | output | N | Bit i high when input i is paired (only while done) |

## Verification
The bound checker watches every cycle for properties of the result. It checks that no two valid entries share an output, that every valid pair was actually requested, and that the round count stays within the clamped limit. It also checks that a full-limit run ends maximal, that a start from the result state drops done, and that a held result does not move. Other behaviours can only be shown by the bench's scenarios. These are the exact two-cycle-per-round timing, early stopping on an idle round, clamping of the limit, exact pairing on exclusive request patterns, a start that is ignored mid-run, and the fact that every contender for one output wins over many runs.

// File: rtl/pim_pkg.sv
package pim_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_GRANT  = 2'd1,
        S_ACCEPT = 2'd2,
        S_DONE   = 2'd3
    } pim_state_e;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    // Odd multiplier keeps every seed nonzero and distinct for k below 65535
    function automatic logic [LFSR_W-1:0] seed_for(input int k);
        seed_for = LFSR_W'((k + 1) * 40503);
    endfunction

endpackage

// File: rtl/pim_lfsr.sv
module pim_lfsr
    import pim_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else begin
            q <= (q >> 1) ^ (q[0] ? LFSR_TAPS : '0);
        end
    end

endmodule

// File: rtl/pim_pick.sv
module pim_pick #(
    parameter int N = 16,
    localparam int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    cand,
    input  logic [IDXW-1:0] rot,
    output logic [N-1:0]    sel
);

    logic [N-1:0]    rotd;
    logic [IDXW-1:0] first;
    logic [IDXW:0]   sum;

    // Rotate the candidates right by rot so that position k views candidate k+rot
    always_comb begin
        for (int k = 0; k < N; k++) begin
            int p;
            p = k + int'(rot);
            if (p >= N) p = p - N;
            rotd[k] = cand[p];
        end
    end

    always_comb begin
        first = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rotd[k]) first = IDXW'(k);
        end
        sum = {1'b0, first} + {1'b0, rot};
        if (sum >= (IDXW+1)'(N)) sum = sum - (IDXW+1)'(N);
        sel = '0;
        if (|cand) sel[sum[IDXW-1:0]] = 1'b1;
    end

endmodule

// File: rtl/pim_sched.sv
module pim_sched
    import pim_pkg::*;
#(
    parameter int N = 16,
    localparam int IDXW = $clog2(N),
    localparam int ITW  = $clog2(N + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [N*N-1:0]      req_mat,
    input  logic [ITW-1:0]      iter_lim,
    output logic                done,
    output logic [N*IDXW-1:0]   match_idx,
    output logic [N-1:0]        match_vld
);

    pim_state_e state_q, state_d;

    logic [N*N-1:0]           req_q;
    logic [ITW-1:0]           lim_q, it_cnt, lim_eff;
    logic [N-1:0]             in_m, out_m, new_out, any_a;
    logic [N-1:0][IDXW-1:0]   in_idx, idx_a, rot_g, rot_a;
    logic [N-1:0][N-1:0]      gnt_q;     // [output][input]
    logic [N-1:0][N-1:0]      cand_g, sel_g, cand_a, sel_a;
    logic [N-1:0][LFSR_W-1:0] lf_g, lf_a;
    logic                     launch, finish;

    function automatic logic [IDXW-1:0] oh2idx(input logic [N-1:0] oh);
        oh2idx = '0;
        for (int k = 0; k < N; k++) begin
            if (oh[k]) oh2idx = oh2idx | IDXW'(k);
        end
    endfunction

    // Request phase: unpaired inputs ask unpaired outputs they hold cells for
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                cand_g[j][i] = req_q[i*N + j] & ~in_m[i] & ~out_m[j];
                cand_a[i][j] = gnt_q[j][i];
            end
        end
    end

    generate
        for (genvar k = 0; k < N; k++) begin : g_port
            pim_lfsr #(.SEED(seed_for(k))) u_lfsr_g (
                .clk  (clk),
                .rst_n(rst_n),
                .q    (lf_g[k])
            );
            pim_lfsr #(.SEED(seed_for(k + N))) u_lfsr_a (
                .clk  (clk),
                .rst_n(rst_n),
                .q    (lf_a[k])
            );
            assign rot_g[k] = IDXW'(lf_g[k] % LFSR_W'(N));
            assign rot_a[k] = IDXW'(lf_a[k] % LFSR_W'(N));

            // Grant phase chooser for output k
            pim_pick #(.N(N)) u_pick_g (
                .cand(cand_g[k]),
                .rot (rot_g[k]),
                .sel (sel_g[k])
            );
            // Accept phase chooser for input k
            pim_pick #(.N(N)) u_pick_a (
                .cand(cand_a[k]),
                .rot (rot_a[k]),
                .sel (sel_a[k])
            );
            assign any_a[k] = |sel_a[k];
            assign idx_a[k] = oh2idx(sel_a[k]);
        end
    endgenerate

    always_comb begin
        new_out = '0;
        for (int i = 0; i < N; i++) new_out = new_out | sel_a[i];
    end

    always_comb begin
        if (iter_lim == '0)           lim_eff = ITW'(1);
        else if (iter_lim > ITW'(N))  lim_eff = ITW'(N);
        else                          lim_eff = iter_lim;
    end

    assign launch = start && (state_q == S_IDLE || state_q == S_DONE);
    assign finish = (state_q == S_ACCEPT) &&
                    (!(|any_a) || ((it_cnt + ITW'(1)) >= lim_q));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (launch) state_d = S_GRANT;
            S_GRANT:  state_d = S_ACCEPT;
            S_ACCEPT: state_d = finish ? S_DONE : S_GRANT;
            S_DONE:   if (launch) state_d = S_GRANT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Match bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            lim_q  <= '0;
            it_cnt <= '0;
            in_m   <= '0;
            out_m  <= '0;
            in_idx <= '0;
            gnt_q  <= '0;
        end else if (launch) begin
            req_q  <= req_mat;
            lim_q  <= lim_eff;
            it_cnt <= '0;
            in_m   <= '0;
            out_m  <= '0;
            in_idx <= '0;
            gnt_q  <= '0;
        end else if (state_q == S_GRANT) begin
            gnt_q <= sel_g;
        end else if (state_q == S_ACCEPT) begin
            it_cnt <= it_cnt + ITW'(1);
            out_m  <= out_m | new_out;
            for (int i = 0; i < N; i++) begin
                if (any_a[i]) begin
                    in_m[i]   <= 1'b1;
                    in_idx[i] <= idx_a[i];
                end
            end
        end
    end

    // Outputs
    always_comb begin
        done      = (state_q == S_DONE);
        match_vld = done ? in_m : '0;
        for (int i = 0; i < N; i++) begin
            match_idx[i*IDXW +: IDXW] = in_idx[i];
        end
    end

endmodule

// File: rtl/pim_sched_chk.sv
module pim_sched_chk #(
    parameter int N = 16,
    localparam int IDXW = $clog2(N),
    localparam int ITW  = $clog2(N + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [N*N-1:0]    req_q,
    input logic [ITW-1:0]    lim_q,
    input logic [ITW-1:0]    it_cnt,
    input logic [N*IDXW-1:0] match_idx,
    input logic [N-1:0]      match_vld
);

    logic [N-1:0] used;
    logic         dup, badreq, gap;

    always_comb begin
        logic [IDXW-1:0] cur;
        used   = '0;
        dup    = 1'b0;
        badreq = 1'b0;
        gap    = 1'b0;
        for (int i = 0; i < N; i++) begin
            cur = match_idx[i*IDXW +: IDXW];
            if (match_vld[i]) begin
                if (used[cur]) dup = 1'b1;
                used[cur] = 1'b1;
                if (!req_q[i*N + int'(cur)]) badreq = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (req_q[i*N + j] && !match_vld[i] && !used[j]) gap = 1'b1;
            end
        end
    end

    a_r2_start_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done);

    a_r3_pair_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !badreq);

    a_r4_unique_output: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dup);

    a_r5_round_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (it_cnt <= lim_q) && (it_cnt != '0));

    a_r7_maximal_full_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lim_q == ITW'(N)) |-> !gap);

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(match_vld) && $stable(match_idx));

endmodule

bind pim_sched pim_sched_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .req_q    (req_q),
    .lim_q    (lim_q),
    .it_cnt   (it_cnt),
    .match_idx(match_idx),
    .match_vld(match_vld)
);

// File: tb/pim_sched_tb.sv
module pim_sched_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N    = 16;
    localparam int IDXW = 4;
    localparam int ITW  = 5;
    localparam int NV   = 8;

    // Pattern code, round limit, expected latency (-1 = not fixed), tag
    localparam int    V_PAT[NV] = '{0, 1, 2, 3, 4, 4, 5, 6};
    localparam int    V_LIM[NV] = '{16, 1, 16, 0, 16, 20, 4, 16};
    localparam int    V_LAT[NV] = '{4, 2, 2, 2, -1, -1, 4, 4};
    localparam string V_TAG[NV] = '{"R6 identity", "R5 single round", "R6 empty",
                                    "R5 zero limit", "R7 full", "R5 limit above N",
                                    "R6 one row", "R6 one column"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N*N-1:0]    req = '0;
    logic [ITW-1:0]    lim = '0;
    logic              done;
    logic [N*IDXW-1:0] midx;
    logic [N-1:0]      mvld;

    int errs = 0;
    int checks = 0;

    always #4ns clk = ~clk;

    pim_sched #(.N(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_mat  (req),
        .iter_lim (lim),
        .done     (done),
        .match_idx(midx),
        .match_vld(mvld)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [N*N-1:0] pat(input int code);
        logic [N*N-1:0] m = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                case (code)
                    0: m[i*N+j] = (j == i);
                    1: m[i*N+j] = (j == N - 1 - i);
                    3: m[i*N+j] = (i % 2 == 0) && (j == (i + 3) % N);
                    4: m[i*N+j] = 1'b1;
                    5: m[i*N+j] = (i == 0);
                    6: m[i*N+j] = (j == 5);
                    7: m[i*N+j] = (j == 0) && (i % 4 == 0);
                    default: m[i*N+j] = 1'b0;
                endcase
            end
        end
        return m;
    endfunction

    function automatic int idx_of(input int i);
        return int'(midx[i*IDXW +: IDXW]);
    endfunction

    task automatic run(input logic [N*N-1:0] r, input logic [ITW-1:0] l, output int lat);
        @(negedge clk);
        req = r;
        lim = l;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        chk(!done, "R2 done low after start", done, 0);
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        if (!done) chk(1'b0, "R2 run never finished", lat, 0);
    endtask

    // Property checks computed from the ports and the applied requests
    task automatic verify(input logic [N*N-1:0] r, input int leff, input bit exact, input string tag);
        logic [N-1:0] used = '0;
        bit dup = 0, badreq = 0, gap = 0;
        for (int i = 0; i < N; i++) begin
            if (mvld[i]) begin
                if (used[idx_of(i)]) dup = 1;
                used[idx_of(i)] = 1'b1;
                if (!r[i*N + idx_of(i)]) badreq = 1;
            end
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (r[i*N+j] && !mvld[i] && !used[j]) gap = 1;
        chk(!dup, {"R4 duplicate output ", tag}, dup, 0);
        chk(!badreq, {"R3 unrequested pair ", tag}, badreq, 0);
        if (leff == N) chk(!gap, {"R7 not maximal ", tag}, gap, 0);
        if (exact) begin
            for (int i = 0; i < N; i++) begin
                int ej = -1;
                for (int j = 0; j < N; j++) if (r[i*N+j]) ej = j;
                chk(mvld[i] == (ej >= 0), {"R8 valid ", tag}, mvld[i], ej >= 0);
                if (ej >= 0) chk(idx_of(i) == ej, {"R8 index ", tag}, idx_of(i), ej);
            end
        end
    endtask

    initial begin
        #(8ns * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done, "R1 done in reset", done, 0);
        chk(mvld == '0, "R1 valid in reset", mvld, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done, "R1 done after reset", done, 0);
        chk(mvld == '0, "R1 valid after reset", mvld, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int leff;
            logic [N*N-1:0] r;
            r = pat(V_PAT[v]);
            leff = (V_LIM[v] == 0) ? 1 : (V_LIM[v] > N ? N : V_LIM[v]);
            run(r, ITW'(V_LIM[v]), lat);
            if (V_LAT[v] >= 0) chk(lat == V_LAT[v], {"R2 latency ", V_TAG[v]}, lat, V_LAT[v]);
            verify(r, leff, V_PAT[v] <= 3, V_TAG[v]);
            if (V_PAT[v] == 4) chk($countones(mvld) == N, {"R7 full match ", V_TAG[v]}, $countones(mvld), N);
            if (V_PAT[v] == 5) chk(mvld == 16'h0001, "R7 one row", mvld, 1);
            if (V_PAT[v] == 6) chk($countones(mvld) == 1, "R7 one column", $countones(mvld), 1);
        end

        // R9: result held while inputs change
        begin
            logic [N*IDXW-1:0] hi;
            logic [N-1:0] hv;
            hi = midx;
            hv = mvld;
            req = '1;
            lim = ITW'(3);
            repeat (5) @(negedge clk);
            chk(done, "R9 done held", done, 1);
            chk(mvld == hv, "R9 valid held", mvld, hv);
            chk(midx == hi, "R9 index held", midx, hi);
        end

        // R11: start during a run is ignored
        @(negedge clk);
        req = pat(0);
        lim = ITW'(16);
        start = 1'b1;
        @(negedge clk);
        lat = 0;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 4, "R11 busy start ignored", lat, 4);
        verify(pat(0), 16, 1'b1, "R11 identity");

        // R10: every contender for output 0 eventually wins
        begin
            logic [3:0] seen = '0;
            for (int t = 0; t < 200; t++) begin
                run(pat(7), ITW'(1), lat);
                if (t < 4) chk($countones(mvld) == 1, "R10 single winner", $countones(mvld), 1);
                for (int q = 0; q < 4; q++) if (mvld[q*4]) seen[q] = 1'b1;
                repeat (t % 3) @(negedge clk);
            end
            chk(seen == 4'hF, "R10 all contenders won", seen, 15);
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        req = pat(4);
        lim = ITW'(16);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!done, "R1 done after mid-run reset", done, 0);
        chk(mvld == '0, "R1 valid after mid-run reset", mvld, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done, "R1 stays idle", done, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule